// File: doc/BRIEF.md
# Magic Divisor Constant Generator

This unit turns an unsigned 32-bit divisor d (d of at least 1) into the three constants that let a downstream index generator divide by d using only a multiply and a shift. The constants are a right-shift amount, a 32-bit multiplier whose top bit is left for the consumer to supply, and a one-bit flag. The flag selects the round-down variant, where the consumer adds one to the dividend before it multiplies.

A request is a one-cycle pulse on `start_i` with the divisor on `divisor_i`. The shift is fixed at floor(log2 d), so the unit does no search. It runs one 2^(shift+32) by d division on a restoring divider, one quotient bit per cycle. The quotient and remainder then give the multiplier and the flag, and `done_o` pulses for one cycle. The unit also raises a flag when d is a power of two, because then the consumer should use its plain shift mode.

Top module: `magic_div_gen`

## Requirements
- R1: On completion, shift_o equals floor(log2 d), the index of the highest set bit of the divisor.
- R2: Let N = 2^(shift+32), q = floor(N/d), r = N mod d and m = ceil(N/d). When r is greater than 2^shift, magic_o is m with bit 31 cleared and round_down_o is 0.
- R3: When r is at most 2^shift, magic_o is m-1 with bit 31 cleared and round_down_o is 1.
- R4: Bit 31 of magic_o is always 0, because the consumer supplies that bit itself.
- R5: pow2_o is 1 exactly when d is a power of two. In that case magic_o is 0x7FFFFFFF and round_down_o is 1.
- R6: A start_i sampled high at a rising edge while busy_o is low is accepted. busy_o is then high for the next 64 cycles. done_o is high for exactly the one cycle that follows the 65th rising edge after the accepting edge.
- R7: A start_i that arrives while busy_o is high is ignored. The result that follows belongs to the divisor that was accepted earlier.
- R8: A start_i that arrives in the cycle just before done_o is accepted. The results of the first divisor appear on the outputs with done_o high, and busy_o is high in that same cycle. All result outputs hold their values between done pulses.
- R9: After reset, busy_o, done_o, shift_o, magic_o, round_down_o and pow2_o are all 0.
- R10: When d is not a power of two, floor((x + round_down_o) * (2^31 + magic_o) / 2^(32+shift_o)) equals floor(x/d) for every 32-bit x. When d is a power of two, x >> shift_o equals floor(x/d).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; accepted when busy_o is low |
| divisor_i | input | 32 | Divisor d, at least 1, sampled when the request is accepted |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse when new results are presented |
| shift_o | output | 5 | Shift amount, floor(log2 d) |
| magic_o | output | 32 | Multiplier with bit 31 cleared |
| round_down_o | output | 1 | Consumer adds one to the dividend before multiplying |
| pow2_o | output | 1 | Divisor is a power of two; use the shift-only mode |

## Verification
Result capture for one divisor and acceptance of the next request can fall on the same rising edge. The bench raises start_i in the last cycle of a running division, when busy_o has just dropped. In the cycle after that edge it expects done_o high with the first divisor's constants, and busy_o high for the new one. A behavioural model that counts down the latency in the bench checks busy_o, done_o and every result output on each clock. The second result is judged both against the model and by evaluating the consumer's multiply-shift formula on sample dividends.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mdg_state_e;
endpackage

// File: rtl/mdg_log2.sv
module mdg_log2 #(
  parameter int DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] val_i,
  output logic [SW-1:0] log2_o,
  output logic          pow2_o
);
  always_comb begin
    log2_o = '0;
    for (int i = 0; i < DW; i++) begin
      if (val_i[i]) log2_o = SW'(i);
    end
  end

  assign pow2_o = (val_i != '0) && ((val_i & (val_i - DW'(1))) == '0);
endmodule

// File: rtl/mdg_divider.sv
module mdg_divider #(
  parameter int DW = 32,
  localparam int NW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [NW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic [NW-1:0] quot_o,
  output logic [DW-1:0] rem_o
);
  logic [NW-1:0] num_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] div_q;
  logic [DW:0]   trial;
  logic          fits;
  logic [DW:0]   diff;

  // shift one dividend bit into the partial remainder
  assign trial = {rem_q, num_q[NW-1]};
  assign fits  = trial >= {1'b0, div_q};
  assign diff  = trial - {1'b0, div_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      rem_q <= '0;
      div_q <= '0;
    end else if (load_i) begin
      num_q <= dividend_i;
      rem_q <= '0;
      div_q <= divisor_i;
    end else if (step_i) begin
      num_q <= {num_q[NW-2:0], fits};
      rem_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
    end
  end

  assign quot_o = num_q;
  assign rem_o  = rem_q;

  // R2
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && div_q != '0) |=> (rem_q < div_q));
endmodule

// File: rtl/mdg_select.sv
module mdg_select #(
  parameter int DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW:0]   quot_i,
  input  logic [DW-1:0] rem_i,
  input  logic [SW-1:0] shift_i,
  output logic [DW-1:0] magic_o,
  output logic          round_down_o
);
  logic [DW:0] thresh;
  logic [DW:0] m_ceil;
  logic [DW:0] m_pick;

  assign thresh       = (DW+1)'(1) << shift_i;
  assign round_down_o = {1'b0, rem_i} <= thresh;
  assign m_ceil       = quot_i + (DW+1)'(rem_i != '0);
  assign m_pick       = round_down_o ? (m_ceil - (DW+1)'(1)) : m_ceil;
  // top bit is implicit at the consumer
  assign magic_o      = {1'b0, m_pick[DW-2:0]};
endmodule

// File: rtl/magic_div_gen.sv
module magic_div_gen
  import mdg_pkg::*;
#(
  parameter int DW = 32,
  localparam int SW = $clog2(DW),
  localparam int NW = 2 * DW,
  localparam int CW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] shift_o,
  output logic [DW-1:0] magic_o,
  output logic          round_down_o,
  output logic          pow2_o
);
  mdg_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] shift_q;
  logic          pow2_q;
  logic          accept;
  logic [SW-1:0] lg;
  logic          lg_pow2;
  logic [CW-1:0] sh_amt;
  logic [NW-1:0] dividend;
  logic [NW-1:0] quot;
  logic [DW-1:0] rem;
  logic [DW-1:0] sel_magic;
  logic          sel_rd;

  logic          done_q;
  logic [SW-1:0] shift_out_q;
  logic [DW-1:0] magic_out_q;
  logic          rd_out_q;
  logic          pow2_out_q;

  assign accept   = start_i && (state_q != ST_RUN);
  assign sh_amt   = CW'(lg) + CW'(DW);
  assign dividend = NW'(1) << sh_amt;

  mdg_log2 #(.DW(DW)) u_log2 (
    .val_i  (divisor_i),
    .log2_o (lg),
    .pow2_o (lg_pow2)
  );

  mdg_divider #(.DW(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .step_i     (state_q == ST_RUN),
    .dividend_i (dividend),
    .divisor_i  (divisor_i),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  mdg_select #(.DW(DW)) u_sel (
    .quot_i       (quot[DW:0]),
    .rem_i        (rem),
    .shift_i      (shift_q),
    .magic_o      (sel_magic),
    .round_down_o (sel_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      pow2_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(NW - 1)) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (accept) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
        shift_q <= lg;
        pow2_q  <= lg_pow2;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      shift_out_q <= '0;
      magic_out_q <= '0;
      rd_out_q    <= 1'b0;
      pow2_out_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIN);
      if (state_q == ST_FIN) begin
        shift_out_q <= shift_q;
        magic_out_q <= sel_magic;
        rd_out_q    <= sel_rd;
        pow2_out_q  <= pow2_q;
      end
    end
  end

  assign busy_o       = (state_q == ST_RUN);
  assign done_o       = done_q;
  assign shift_o      = shift_out_q;
  assign magic_o      = magic_out_q;
  assign round_down_o = rd_out_q;
  assign pow2_o       = pow2_out_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(shift_q));
  // R5
  pow2_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pow2_o) |-> (round_down_o && magic_o == {1'b0, {(DW-1){1'b1}}}));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(magic_o) || !$stable(shift_o)) |-> done_o);
endmodule

// File: tb/magic_div_gen_test.sv
`timescale 1ns/1ps
module magic_div_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] divisor_i = 32'd1;
  logic        busy_o, done_o, round_down_o, pow2_o;
  logic [4:0]  shift_o;
  logic [31:0] magic_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  magic_div_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .shift_o(shift_o), .magic_o(magic_o),
    .round_down_o(round_down_o), .pow2_o(pow2_o)
  );

  function automatic void ref_calc(input logic [31:0] d, output int s,
                                   output logic [31:0] mg, output logic fl,
                                   output logic p2);
    logic [63:0] n, q, r, m;
    s = 0;
    for (int i = 0; i < 32; i++) if (d[i]) s = i;
    p2 = ((d & (d - 32'd1)) == 32'd0);
    n = 64'd1 << (s + 32);
    q = n / {32'd0, d};
    r = n % {32'd0, d};
    m = q + ((r != 0) ? 64'd1 : 64'd0);
    if (r <= (64'd1 << s)) begin
      mg = 32'(m - 64'd1);
      fl = 1'b1;
    end else begin
      mg = 32'(m);
      fl = 1'b0;
    end
    mg[31] = 1'b0;
  endfunction

  function automatic logic [31:0] idx_div(input logic [31:0] x, input logic [31:0] mg,
                                          input logic fl, input int s, input logic p2);
    logic [127:0] prod;
    if (p2) return x >> s;
    prod = ({96'd0, x} + {127'd0, fl}) * {96'd0, (mg | 32'h8000_0000)};
    return 32'(prod >> (32 + s));
  endfunction

  // behavioural model: latency countdown and held results
  int          m_left = 0;
  logic [31:0] m_d = 32'd0;
  bit          acc;
  logic        e_done = 1'b0;
  int          e_shift = 0;
  logic [31:0] e_magic = 32'd0;
  logic        e_fl = 1'b0;
  logic        e_p2 = 1'b0;
  logic [31:0] e_d = 32'd0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_left = 0; e_done = 1'b0; e_shift = 0; e_magic = 32'd0;
      e_fl = 1'b0; e_p2 = 1'b0;
    end else begin
      acc = start_i && (m_left <= 1);
      e_done = 1'b0;
      if (m_left == 1) begin
        ref_calc(m_d, e_shift, e_magic, e_fl, e_p2);
        e_d = m_d;
        e_done = 1'b1;
      end
      if (m_left > 0) m_left = m_left - 1;
      if (acc) begin
        m_left = 65;
        m_d = divisor_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      checks++;
      if (busy_o !== (m_left >= 2)) begin
        fails++;
        $display("FAIL R6/R7 busy_o=%0b expected %0b", busy_o, (m_left >= 2));
      end
      checks++;
      if (done_o !== e_done) begin
        fails++;
        $display("FAIL R6 done_o=%0b expected %0b", done_o, e_done);
      end
      checks++;
      if (shift_o !== 5'(e_shift)) begin
        fails++;
        $display("FAIL R1 shift_o=%0d expected %0d (d=%h)", shift_o, e_shift, e_d);
      end
      checks++;
      if (magic_o !== e_magic || round_down_o !== e_fl) begin
        fails++;
        $display("FAIL R2/R3 magic_o=%h rd=%0b expected %h rd=%0b (d=%h)",
                 magic_o, round_down_o, e_magic, e_fl, e_d);
      end
      checks++;
      if (pow2_o !== e_p2 || magic_o[31] !== 1'b0) begin
        fails++;
        $display("FAIL R4/R5 pow2_o=%0b bit31=%0b expected pow2 %0b bit31 0",
                 pow2_o, magic_o[31], e_p2);
      end
      if (done_o && e_done) begin
        logic [31:0] xs [4];
        xs[0] = 32'd0; xs[1] = e_d - 32'd1; xs[2] = $urandom; xs[3] = 32'hFFFF_FFFF;
        for (int k = 0; k < 4; k++) begin
          logic [31:0] got;
          got = idx_div(xs[k], magic_o, round_down_o, int'(shift_o), pow2_o);
          checks++;
          if (got !== xs[k] / e_d) begin
            fails++;
            $display("FAIL R10 x=%h d=%h formula=%h expected %h", xs[k], e_d, got, xs[k] / e_d);
          end
        end
      end
    end
  end

  task automatic wait_idle();
    while (m_left != 0 || busy_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic go(input logic [31:0] d);
    wait_idle();
    start_i = 1'b1;
    divisor_i = d;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic check_one(input string tag, input logic ok, input logic [31:0] act,
                           input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int s7; logic [31:0] mg7; logic fl7; logic p7;
    logic [31:0] dl [16];
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check_one("R9 outputs after reset",
              {busy_o, done_o, shift_o, magic_o, round_down_o, pow2_o} == '0,
              magic_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    dl[0] = 32'd1;  dl[1] = 32'd2;  dl[2] = 32'd3;  dl[3] = 32'd5;
    dl[4] = 32'd7;  dl[5] = 32'd10; dl[6] = 32'd12; dl[7] = 32'd100;
    dl[8] = 32'd1000; dl[9] = 32'h8000_0000; dl[10] = 32'hFFFF_FFFF;
    dl[11] = 32'h7FFF_FFFF; dl[12] = 32'h8000_0001; dl[13] = 32'd9;
    dl[14] = 32'd4096; dl[15] = 32'd70;
    for (int i = 0; i < 16; i++) go(dl[i]);
    for (int i = 0; i < 24; i++) begin
      logic [31:0] d;
      d = $urandom >> ($urandom % 32);
      if (d == 0) d = 32'd11;
      go(d);
    end

    // R7: request while busy is ignored
    go(32'd7);
    repeat (10) @(negedge clk_i);
    start_i = 1'b1; divisor_i = 32'd9;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_idle();
    ref_calc(32'd7, s7, mg7, fl7, p7);
    check_one("R7 result after ignored request", magic_o == mg7 && shift_o == 5'(s7),
              magic_o, mg7);

    // R8: new request in the last cycle of a division
    go(32'd11);
    while (m_left != 1) @(negedge clk_i);
    start_i = 1'b1; divisor_i = 32'd13;
    @(negedge clk_i);
    start_i = 1'b0;
    ref_calc(32'd11, s7, mg7, fl7, p7);
    check_one("R8 done and busy together", done_o && busy_o, {30'd0, done_o, busy_o}, 32'd3);
    check_one("R8 first result on done", magic_o == mg7, magic_o, mg7);
    wait_idle();
    ref_calc(32'd13, s7, mg7, fl7, p7);
    check_one("R8 second result", magic_o == mg7 && shift_o == 5'(s7), magic_o, mg7);

    repeat (5) @(negedge clk_i);
    report();
  end
endmodule